// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide flash array and watches every bus write. Mode changes need exact address and data pairs across consecutive writes. A wrong pair aborts the sequence and the block returns to plain array reads. Recognised sequences start a byte program, a whole-array erase or an erase of one 4 KB sector. Another sequence switches reads over to the identification bytes. Each start drives a one-cycle strobe toward the array and a busy period whose length is a parameter.

While the block is busy it ignores writes and answers reads with a status byte. Bit 7 of that byte is the complement of the data bit being written, and bit 6 changes on every read. From this the host can tell when the operation has finished. Reads are registered: the byte for a read strobe appears on the output in the cycle after it.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, busy, the write strobe and both erase strobes are low, and a read returns the array byte at the read address.
- R2: Only the low 15 address bits are compared against the key addresses 5555h and 2AAAh. A sequence advances only on AAh at 5555h followed by 55h at 2AAAh. Any other write aborts the sequence and returns to array reads, which also leaves identification mode.
- R3: After the unlock pair, A0h at 5555h arms a program. The next write raises arrWrEn for exactly one cycle, carrying that write's address and data.
- R4: After the unlock pair, the sequence 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 10h at 5555h pulses arrEraseChip for one cycle after the sixth write. No erase strobe and no busy appears after the fifth write.
- R5: The same sequence ending in 30h at any address pulses arrEraseSector, with arrSector set to address bits 18:12 of that sixth write.
- R6: Busy rises with each operation strobe and stays high for BUSY_CYCLES cycles. Any write that reaches a clock edge while busy is high is ignored.
- R7: A read while busy returns the complement of the programmed data bit 7 in bit 7 (0 during an erase) and zero in bits 5:0.
- R8: Bit 6 of the status byte is 0 on the first read of each operation and inverts on every further read while busy.
- R9: After the unlock pair, 90h at 5555h enters identification mode. In this mode a read at an odd address returns DEV_ID (default B7h) and a read at an even address returns MFR_ID.
- R10: A single write of F0h to any address leaves identification mode. The unlock pair followed by F0h at 5555h also leaves it.
- R11: Read data is registered and is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| arrRdAddr | output | ADDR_W | Array read address |
| arrRdData | input | 8 | Array byte at arrRdAddr |
| arrWrEn | output | 1 | One-cycle program strobe |
| arrWrAddr | output | ADDR_W | Program address |
| arrWrData | output | 8 | Program data |
| arrEraseChip | output | 1 | One-cycle whole-array erase strobe |
| arrEraseSector | output | 1 | One-cycle sector erase strobe |
| arrSector | output | ADDR_W-12 | Sector index for a sector erase |
| busy | output | 1 | High while an operation runs |

## Verification
The end of the busy period and a new command write can fall in the same cycle. The bench places the first unlock write of an identification entry on the last busy edge in one run, and one edge later in another. The judgement is made at the ports: a later read at an odd address returns the array byte when that unlock write was dropped, and DEV_ID when it was accepted.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam logic [7:0] CMD_KEY_A     = 8'hAA;
  localparam logic [7:0] CMD_KEY_B     = 8'h55;
  localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
  localparam logic [7:0] CMD_ERASE_PRE = 8'h80;
  localparam logic [7:0] CMD_ERASE_ALL = 8'h10;
  localparam logic [7:0] CMD_ERASE_SEC = 8'h30;
  localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
  localparam logic [7:0] CMD_ID_LEAVE  = 8'hF0;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEYED1,
    SEQ_KEYED2,
    SEQ_PGM_ARM,
    SEQ_ERS_PRE,
    SEQ_ERS_KEY1,
    SEQ_ERS_KEY2
  } seqState_t;

  typedef struct packed {
    logic startPgm;
    logic startChip;
    logic startSector;
    logic idMode;
  } ctrlStrb_t;

endpackage

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int CMD_ADDR_W = 15,
  parameter logic [CMD_ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [CMD_ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic [7:0]            busWrData,
  input  logic                  busy,
  output ctrlStrb_t             strb
);

  seqState_t stateQ, stateNext;
  logic      idModeQ, idModeNext;
  logic      accept, atKeyA, atKeyB;

  assign accept = busWr && !busy;
  assign atKeyA = (cmdAddr == KEY_ADDR_A);
  assign atKeyB = (cmdAddr == KEY_ADDR_B);

  always_comb begin
    stateNext        = stateQ;
    idModeNext       = idModeQ;
    strb.startPgm    = 1'b0;
    strb.startChip   = 1'b0;
    strb.startSector = 1'b0;
    strb.idMode      = idModeQ;
    if (accept) begin
      // default for every accepted write: back to reads, out of id mode
      stateNext  = SEQ_IDLE;
      idModeNext = 1'b0;
      case (stateQ)
        SEQ_IDLE: begin
          if (busWrData == CMD_KEY_A && atKeyA) begin
            stateNext  = SEQ_KEYED1;
            idModeNext = idModeQ;
          end
        end
        SEQ_KEYED1: begin
          if (busWrData == CMD_KEY_B && atKeyB) begin
            stateNext  = SEQ_KEYED2;
            idModeNext = idModeQ;
          end
        end
        SEQ_KEYED2: begin
          if (atKeyA) begin
            case (busWrData)
              CMD_PROGRAM:   stateNext = SEQ_PGM_ARM;
              CMD_ERASE_PRE: stateNext = SEQ_ERS_PRE;
              CMD_ID_ENTER:  idModeNext = 1'b1;
              default:       stateNext = SEQ_IDLE;
            endcase
          end
        end
        SEQ_PGM_ARM: strb.startPgm = 1'b1;
        SEQ_ERS_PRE: begin
          if (busWrData == CMD_KEY_A && atKeyA) stateNext = SEQ_ERS_KEY1;
        end
        SEQ_ERS_KEY1: begin
          if (busWrData == CMD_KEY_B && atKeyB) stateNext = SEQ_ERS_KEY2;
        end
        SEQ_ERS_KEY2: begin
          if (busWrData == CMD_ERASE_ALL && atKeyA) strb.startChip = 1'b1;
          else if (busWrData == CMD_ERASE_SEC)      strb.startSector = 1'b1;
        end
        default: stateNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= SEQ_IDLE;
      idModeQ <= 1'b0;
    end else begin
      stateQ  <= stateNext;
      idModeQ <= idModeNext;
    end
  end

  // R6: a write that meets busy leaves the sequence untouched
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWr) |=> ($stable(stateQ) && $stable(idModeQ)));

  // R10: F0h accepted anywhere in any state leaves id mode
  assert_id_leave_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busy && busWrData == CMD_ID_LEAVE) |=> !idModeQ);

  // R2: a write outside a key address never lets the sequence advance
  assert_key_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busy && stateQ == SEQ_IDLE && !atKeyA) |=> (stateQ == SEQ_IDLE));

endmodule

// File: rtl/flashcmd_dp.sv
module flashcmd_dp
  import flashcmd_pkg::*;
#(
  parameter int          ADDR_W      = 19,
  parameter int          SECTOR_LSB  = 12,
  parameter int          BUSY_CYCLES = 20,
  parameter logic [7:0]  MFR_ID      = 8'h3D,
  parameter logic [7:0]  DEV_ID      = 8'hB7,
  localparam int         SECT_W      = ADDR_W - SECTOR_LSB,
  localparam int         CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        arrRdData,
  output logic [7:0]        busRdData,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData,
  output logic              arrEraseChip,
  output logic              arrEraseSector,
  output logic [SECT_W-1:0] arrSector
);

  logic [CNT_W-1:0] busyCntQ;
  logic             togQ;
  logic             polarQ;
  logic             anyStart;
  logic [7:0]       rdNext;

  assign anyStart = strb.startPgm || strb.startChip || strb.startSector;
  assign busy     = (busyCntQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCntQ <= '0;
    else if (anyStart) busyCntQ <= CNT_W'(BUSY_CYCLES);
    else if (busy) busyCntQ <= busyCntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrWrEn        <= 1'b0;
      arrEraseChip   <= 1'b0;
      arrEraseSector <= 1'b0;
      arrWrAddr      <= '0;
      arrWrData      <= '0;
      arrSector      <= '0;
      polarQ         <= 1'b0;
    end else begin
      arrWrEn        <= strb.startPgm;
      arrEraseChip   <= strb.startChip;
      arrEraseSector <= strb.startSector;
      if (strb.startPgm) begin
        arrWrAddr <= busAddr;
        arrWrData <= busWrData;
        polarQ    <= busWrData[7];
      end
      if (strb.startChip || strb.startSector) polarQ <= 1'b1;
      if (strb.startSector) arrSector <= busAddr[ADDR_W-1:SECTOR_LSB];
    end
  end

  always_comb begin
    if (busy)             rdNext = {~polarQ, togQ, 6'b0};
    else if (strb.idMode) rdNext = busAddr[0] ? DEV_ID : MFR_ID;
    else                  rdNext = arrRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togQ      <= 1'b0;
      busRdData <= '0;
    end else begin
      if (anyStart) togQ <= 1'b0;
      else if (busRd && busy) togQ <= ~togQ;
      if (busRd) busRdData <= rdNext;
    end
  end

  // R3: at most one array operation strobe at a time
  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrWrEn, arrEraseChip, arrEraseSector}));

  // R3: the program strobe lasts a single cycle
  assert_pgm_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |=> !arrWrEn);

  // R6: every operation strobe is covered by busy
  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn || arrEraseChip || arrEraseSector) |-> busy);

  // R8: back-to-back busy reads return opposite bit 6
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busRd && $past(busy && busRd)) |=> (busRdData[6] != $past(busRdData[6])));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flashcmd_pkg::*;
#(
  parameter int         ADDR_W      = 19,
  parameter int         CMD_ADDR_W  = 15,
  parameter int         SECTOR_LSB  = 12,
  parameter int         BUSY_CYCLES = 20,
  parameter logic [7:0] MFR_ID      = 8'h3D,
  parameter logic [7:0] DEV_ID      = 8'hB7,
  localparam int        SECT_W      = ADDR_W - SECTOR_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [ADDR_W-1:0] arrRdAddr,
  input  logic [7:0]        arrRdData,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData,
  output logic              arrEraseChip,
  output logic              arrEraseSector,
  output logic [SECT_W-1:0] arrSector,
  output logic              busy
);

  ctrlStrb_t strb;

  assign arrRdAddr = busAddr;

  flashcmd_ctrl #(
    .CMD_ADDR_W (CMD_ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .cmdAddr   (busAddr[CMD_ADDR_W-1:0]),
    .busWrData (busWrData),
    .busy      (busy),
    .strb      (strb)
  );

  flashcmd_dp #(
    .ADDR_W      (ADDR_W),
    .SECTOR_LSB  (SECTOR_LSB),
    .BUSY_CYCLES (BUSY_CYCLES),
    .MFR_ID      (MFR_ID),
    .DEV_ID      (DEV_ID)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .busRd          (busRd),
    .busAddr        (busAddr),
    .busWrData      (busWrData),
    .arrRdData      (arrRdData),
    .busRdData      (busRdData),
    .busy           (busy),
    .arrWrEn        (arrWrEn),
    .arrWrAddr      (arrWrAddr),
    .arrWrData      (arrWrData),
    .arrEraseChip   (arrEraseChip),
    .arrEraseSector (arrEraseSector),
    .arrSector      (arrSector)
  );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 12;
  localparam logic [7:0] MFR = 8'h3D;
  localparam logic [7:0] DEV = 8'hB7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [18:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData, arrRdData, arrWrData;
  logic [18:0] arrRdAddr, arrWrAddr;
  logic        arrWrEn, arrEraseChip, arrEraseSector, busy;
  logic [6:0]  arrSector;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // array model: fixed pattern by low address byte
  function automatic logic [7:0] arrByte(input logic [18:0] a);
    return a[7:0] * 8'd3 + 8'd1;
  endfunction
  assign arrRdData = arrByte(arrRdAddr);

  flash_cmd_decoder #(.BUSY_CYCLES(BUSY), .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .arrRdAddr(arrRdAddr),
    .arrRdData(arrRdData), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData), .arrEraseChip(arrEraseChip),
    .arrEraseSector(arrEraseSector), .arrSector(arrSector), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  // monitor: compare registered read data one cycle after each strobe (R11)
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected read", 32'(busRdData), 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(busRdData == e, t, 32'(busRdData), 32'(e));
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk(!busy && !arrWrEn && !arrEraseChip && !arrEraseSector, "R1 reset outputs",
        {busy, arrWrEn, arrEraseChip, arrEraseSector}, 0);
    rd(19'h00001, arrByte(19'h1), "R1 R11 array read after reset");

    // R3 program with data bit7 = 0
    unlock(); wr(19'h05555, 8'hA0);
    wr(19'h12345, 8'h3C);
    chk(arrWrEn, "R3 program strobe", arrWrEn, 1);
    chk(arrWrAddr == 19'h12345, "R3 program address", arrWrAddr, 19'h12345);
    chk(arrWrData == 8'h3C, "R3 program data", arrWrData, 8'h3C);
    chk(busy, "R6 busy after program start", busy, 1);
    rd(19'h00000, 8'h80, "R7 R8 first status read");
    chk(!arrWrEn, "R3 strobe one cycle", arrWrEn, 0);
    rd(19'h00000, 8'hC0, "R8 second status read toggles");
    idle(9);
    wr(19'h05555, 8'hAA);           // lands on last busy edge: dropped
    chk(!busy, "R6 busy length", busy, 0);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'h90);
    rd(19'h00001, arrByte(19'h1), "R6 write in last busy cycle ignored");

    // R7 program with data bit7 = 1, then first accepted cycle after busy
    unlock(); wr(19'h05555, 8'hA0);
    wr(19'h00077, 8'hA5);
    rd(19'h00003, 8'h00, "R7 status bit7 inverted");
    idle(11);
    unlock(); wr(19'h05555, 8'h90);
    rd(19'h00001, DEV, "R6 R9 write after busy accepted, device id");
    rd(19'h40000, MFR, "R9 even address maker id");
    rd(19'h7FFFF, DEV, "R9 odd address device id");

    // R10 single-write exit
    wr(19'h01234, 8'hF0);
    rd(19'h00005, arrByte(19'h5), "R10 single F0 exit");

    // R2 upper bits ignored in key address, R10 three-write exit
    wr(19'h45555, 8'hAA); wr(19'h7AAAA, 8'h55); wr(19'h05555, 8'h90);
    rd(19'h00001, DEV, "R2 key match on low 15 bits");
    unlock(); wr(19'h05555, 8'hF0);
    rd(19'h00001, arrByte(19'h1), "R10 three-write exit");

    // R2 abort cases
    unlock(); wr(19'h05554, 8'hA0);
    wr(19'h00100, 8'h11);
    chk(!arrWrEn && !busy, "R2 wrong address aborts program", {arrWrEn, busy}, 0);
    unlock(); wr(19'h05555, 8'h90);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h56);
    rd(19'h00001, arrByte(19'h1), "R2 wrong data aborts and leaves id mode");

    // R4 chip erase
    unlock(); wr(19'h05555, 8'h80); unlock();
    chk(!busy && !arrEraseChip && !arrEraseSector, "R4 nothing after fifth write",
        {busy, arrEraseChip, arrEraseSector}, 0);
    wr(19'h05555, 8'h10);
    chk(arrEraseChip && !arrEraseSector, "R4 chip erase strobe", {arrEraseChip, arrEraseSector}, 2);
    chk(busy, "R6 busy after erase", busy, 1);
    rd(19'h00009, 8'h00, "R7 R8 erase status first read");
    rd(19'h00009, 8'h40, "R8 erase status second read");
    idle(BUSY);

    // R5 sector erase
    unlock(); wr(19'h05555, 8'h80); unlock();
    wr(19'h5A123, 8'h30);
    chk(arrEraseSector && !arrEraseChip, "R5 sector erase strobe", {arrEraseSector, arrEraseChip}, 2);
    chk(arrSector == 7'h5A, "R5 sector index", arrSector, 7'h5A);
    idle(BUSY + 1);
    chk(!busy, "R6 busy clears after sector erase", busy, 0);
    rd(19'h00002, arrByte(19'h2), "R1 array read after operations");
    idle(2);

    finished = 1;
    summary();
  end

endmodule